// File: doc/BRIEF.md
# Loop-bound predicate mask generator

This block turns a pair of scalar loop bounds into a vector predicate. Each byte lane of the vector has one predicate bit. The block sets the bits of the leading elements, meaning the iterations of a counted loop for which "first bound plus element index" still satisfies the chosen compare against the second bound. It is meant to sit beside a vector issue stage, which hands it the two scalar operands and the decoded compare variant and takes back the predicate together with a four-bit condition summary.

The computation runs in the following order:

1. Both operands are extended to 64 bits. In 32-bit mode they are first narrowed, then sign- or zero-extended according to the signedness select.
2. The active-element count is formed from the difference of the two bounds. The inclusive forms add one to it.
3. In the inclusive forms, a second bound at the largest representable integer forces a full vector. An ever-incrementing loop can never fail that compare.
4. The count is clamped to the number of elements in the vector.
5. The count is cleared when the compare fails on the very first element.
6. The element count is scaled to predicate bits and expanded, so that only the lowest bit of each active element is set.

Results are registered and appear one clock after the request. The vector length is a parameter.

Top module: `loop_pred_gen`

## Requirements
- R1: With `wide_sel`=0 only bits [31:0] of each bound are used, sign-extended when `unsigned_sel`=0 and zero-extended when `unsigned_sel`=1; bits [63:32] have no effect on the result.
- R2: With `inclusive_sel`=0 the number of active elements is the second bound minus the first bound, when the compare holds and before clamping.
- R3: With `inclusive_sel`=1 the number of active elements is one more than that difference (equal bounds give exactly one active element).
- R4: With `inclusive_sel`=1, a second bound equal to the largest integer for the selected width and signedness makes every element active, whatever the first bound is (64-bit unsigned all-ones, 64-bit signed 0x7FFF_FFFF_FFFF_FFFF, 32-bit unsigned 0xFFFF_FFFF, 32-bit signed 0x7FFF_FFFF).
- R5: The element count is clamped, as an unsigned value, to VLEN_BITS/8 shifted right by `elem_size`.
- R6: If the first bound is not below the second bound (exclusive forms) or is above it (inclusive forms), the mask is all zeros.
- R7: `unsigned_sel`=1 selects unsigned compare and `unsigned_sel`=0 selects two's-complement compare, for both the less-than and the less-or-equal form.
- R8: `elem_size` codes 0, 1, 2 and 3 select elements of 1, 2, 4 and 8 bytes. Active element e sets only predicate bit e·2^`elem_size`. All other bits are zero, and the active elements are always elements 0 to count-1.
- R9: `flag_n` is 1 when element 0 is active. `flag_z` is 1 when no bit is set. `flag_c` is 1 when the last element (lowest bit index VLEN_BITS/8 − 2^`elem_size`) is inactive. `flag_v` is always 0.
- R10: A request with `in_valid`=1 shows up on the outputs after the next rising clock edge, with `out_valid`=1. While `in_valid`=0 the outputs hold and `out_valid`=0. Synchronous reset (`rst_n`=0) gives `out_valid`=0, mask 0, `flag_n`=0, `flag_z`=1, `flag_c`=1 and `flag_v`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe; captures the operands |
| bound_a | input | 64 | First (start) loop bound |
| bound_b | input | 64 | Second (limit) loop bound |
| wide_sel | input | 1 | 1 = 64-bit operands, 0 = 32-bit operands |
| unsigned_sel | input | 1 | 1 = unsigned compare, 0 = signed compare |
| inclusive_sel | input | 1 | 1 = less-or-equal, 0 = less-than |
| elem_size | input | 2 | Element size code: 0 byte, 1 half, 2 word, 3 double |
| out_valid | output | 1 | Result registers were loaded in the previous cycle |
| pmask | output | VLEN_BITS/8 | Predicate, one bit per vector byte |
| flag_n | output | 1 | First element active |
| flag_z | output | 1 | No element active |
| flag_c | output | 1 | Last element inactive |
| flag_v | output | 1 | Always zero |

## Verification
The assertions assume that the inputs are stable and known whenever `in_valid` is high at a rising edge. They also assume that `elem_size` is one of the four codes, which with a 2-bit port holds for any value. They assume nothing about the relation between the bounds: the full-vector and empty-mask properties are written for any first bound. The stimulus drives every request on the falling edge and holds it through the capturing edge. It mixes fully random 64-bit bounds with bounds a few elements apart in either order, so that partial masks, clamped masks and empty masks all occur. A separate pass puts the second bound on each of the four maximum integers, together with start bounds at zero and just below the maximum.

// File: rtl/lpg_pkg.sv
// Package: shared mode struct and operand helpers for the loop-bound
// predicate generator. Assumes operands are carried at 64 bits.
package lpg_pkg;

    localparam int OPW = 64;

    // Decoded compare variant for one request.
    typedef struct packed {
        logic wide;   // 1: 64-bit operands
        logic uns;    // 1: unsigned compare
        logic incl;   // 1: less-or-equal form
    } cmp_mode_t;

    // Narrow to 32 bits when required and extend back to the full width.
    function automatic logic [OPW-1:0] widen(input logic [OPW-1:0] v,
                                             input logic wide,
                                             input logic uns);
        if (wide)
            return v;
        else if (uns)
            return {32'b0, v[31:0]};
        else
            return {{32{v[31]}}, v[31:0]};
    endfunction

    // Largest representable integer for a width/signedness pair, extended.
    function automatic logic [OPW-1:0] top_value(input logic wide,
                                                 input logic uns);
        if (wide)
            return uns ? {OPW{1'b1}} : {1'b0, {(OPW-1){1'b1}}};
        else
            return uns ? {32'b0, {32{1'b1}}} : {33'b0, {31{1'b1}}};
    endfunction

endpackage

// File: rtl/lpg_operand_prep.sv
// Module: lpg_operand_prep
// Brings both bounds to a common 64-bit form so later compares and
// subtraction can ignore the operand width. Assumes the upper half of a
// 32-bit operand carries no meaning. Purely combinational.
module lpg_operand_prep
    import lpg_pkg::*;
(
    input  logic [OPW-1:0] raw_a,
    input  logic [OPW-1:0] raw_b,
    input  cmp_mode_t      mode,
    output logic [OPW-1:0] ext_a,
    output logic [OPW-1:0] ext_b
);

    // Extend each bound according to width and signedness.
    always_comb begin
        ext_a = widen(raw_a, mode.wide, mode.uns);
        ext_b = widen(raw_b, mode.wide, mode.uns);
    end

endmodule

// File: rtl/lpg_count_calc.sv
// Module: lpg_count_calc
// Computes the number of active elements from extended bounds: difference,
// inclusive increment, full vector at the maximum integer, unsigned clamp
// to the element count and the first-iteration compare. Assumes the inputs
// come from lpg_operand_prep. Combinational; clk/rst_n only serve checks.
module lpg_count_calc
    import lpg_pkg::*;
#(
    parameter int VB = 32,
    parameter int CW = $clog2(VB) + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [OPW-1:0] ext_a,
    input  logic [OPW-1:0] ext_b,
    input  cmp_mode_t      mode,
    input  logic [1:0]     esz,
    output logic [CW-1:0]  elem_cnt
);

    logic [CW-1:0]  n_elem;
    logic [OPW-1:0] diff;
    logic [OPW-1:0] span;
    logic           at_top;
    logic [CW-1:0]  clamped;
    logic           lt_u;
    logic           lt_s;
    logic           same;
    logic           start_ok;

    // Element capacity of the vector for this element size.
    always_comb n_elem = CW'(VB) >> esz;

    // Raw span of the loop, one longer for the inclusive forms.
    always_comb begin
        diff = ext_b - ext_a;
        span = mode.incl ? diff + 64'd1 : diff;
    end

    // Inclusive bound at the largest integer can never end the loop.
    always_comb at_top = mode.incl && (ext_b == top_value(mode.wide, mode.uns));

    // Unsigned clamp of the span to the element capacity.
    always_comb begin
        if (at_top)
            clamped = n_elem;
        else if (span < OPW'(n_elem))
            clamped = span[CW-1:0];
        else
            clamped = n_elem;
    end

    // Compare on the first iteration, signed or unsigned.
    always_comb begin
        lt_u     = ext_a < ext_b;
        lt_s     = $signed(ext_a) < $signed(ext_b);
        same     = ext_a == ext_b;
        start_ok = (mode.uns ? lt_u : lt_s) || (mode.incl && same);
    end

    // Final element count.
    always_comb elem_cnt = start_ok ? clamped : '0;

    AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        elem_cnt <= n_elem);  // R5

endmodule

// File: rtl/lpg_mask_expand.sv
// Module: lpg_mask_expand
// Scales the element count to predicate bits and sets, below that bit
// count, only the first bit of each element. Assumes elem_cnt never exceeds
// the element capacity, so the scaled count fits in CW bits.
module lpg_mask_expand #(
    parameter int VB = 32,
    parameter int CW = $clog2(VB) + 1
) (
    input  logic [CW-1:0] elem_cnt,
    input  logic [1:0]    esz,
    output logic [VB-1:0] mask
);

    logic [CW-1:0] bit_cnt;
    logic [CW-1:0] lane_low;

    // Predicate-bit count and the in-element offset mask.
    always_comb begin
        bit_cnt  = elem_cnt << esz;
        lane_low = (CW'(1) << esz) - CW'(1);
    end

    // One comparator per predicate bit.
    for (genvar i = 0; i < VB; i++) begin : g_bit
        localparam logic [CW-1:0] IDX = CW'(i);
        assign mask[i] = (IDX < bit_cnt) && ((IDX & lane_low) == '0);
    end

endmodule

// File: rtl/lpg_flag_calc.sv
// Module: lpg_flag_calc
// Derives the condition summary from a finished mask: first element
// active, none active, last element inactive, overflow clear. Assumes the
// mask has the element-aligned form from lpg_mask_expand.
module lpg_flag_calc #(
    parameter int VB = 32
) (
    input  logic [VB-1:0] mask,
    input  logic [1:0]    esz,
    output logic          f_n,
    output logic          f_z,
    output logic          f_c,
    output logic          f_v
);

    localparam int IW = $clog2(VB);

    logic [IW-1:0] last_lsb;

    // Lowest bit index of the final element.
    always_comb last_lsb = IW'(VB - (1 << esz));

    // Flag values.
    always_comb begin
        f_n = mask[0];
        f_z = ~|mask;
        f_c = ~mask[last_lsb];
        f_v = 1'b0;
    end

endmodule

// File: rtl/loop_pred_gen.sv
// Module: loop_pred_gen (top)
// Produces a leading-elements predicate and condition flags from two loop
// bounds, registered one cycle after in_valid. Assumes VLEN_BITS is a
// multiple of 128 between 128 and 2048. Synchronous active-low reset.
module loop_pred_gen
    import lpg_pkg::*;
#(
    parameter int VLEN_BITS = 256,
    localparam int VB = VLEN_BITS / 8,
    localparam int CW = $clog2(VB) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [63:0]   bound_a,
    input  logic [63:0]   bound_b,
    input  logic          wide_sel,
    input  logic          unsigned_sel,
    input  logic          inclusive_sel,
    input  logic [1:0]    elem_size,
    output logic          out_valid,
    output logic [VB-1:0] pmask,
    output logic          flag_n,
    output logic          flag_z,
    output logic          flag_c,
    output logic          flag_v
);

    cmp_mode_t      mode;
    logic [OPW-1:0] ext_a;
    logic [OPW-1:0] ext_b;
    logic [CW-1:0]  elem_cnt;
    logic [VB-1:0]  mask_d;
    logic           n_d;
    logic           z_d;
    logic           c_d;
    logic           v_d;
    logic [1:0]     esz_q;
    logic [VB-1:0]  lane_pat;

    // Pack the mode selects.
    always_comb mode = '{wide: wide_sel, uns: unsigned_sel, incl: inclusive_sel};

    lpg_operand_prep u_prep (
        .raw_a (bound_a),
        .raw_b (bound_b),
        .mode  (mode),
        .ext_a (ext_a),
        .ext_b (ext_b)
    );

    lpg_count_calc #(.VB(VB), .CW(CW)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_a    (ext_a),
        .ext_b    (ext_b),
        .mode     (mode),
        .esz      (elem_size),
        .elem_cnt (elem_cnt)
    );

    lpg_mask_expand #(.VB(VB), .CW(CW)) u_expand (
        .elem_cnt (elem_cnt),
        .esz      (elem_size),
        .mask     (mask_d)
    );

    lpg_flag_calc #(.VB(VB)) u_flags (
        .mask (mask_d),
        .esz  (elem_size),
        .f_n  (n_d),
        .f_z  (z_d),
        .f_c  (c_d),
        .f_v  (v_d)
    );

    // Result registers, loaded on each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            pmask     <= '0;
            flag_n    <= 1'b0;
            flag_z    <= 1'b1;
            flag_c    <= 1'b1;
            flag_v    <= 1'b0;
            esz_q     <= 2'd0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                pmask  <= mask_d;
                flag_n <= n_d;
                flag_z <= z_d;
                flag_c <= c_d;
                flag_v <= v_d;
                esz_q  <= elem_size;
            end
        end
    end

    // Allowed bit positions for the registered element size (checks only).
    always_comb begin
        for (int i = 0; i < VB; i++)
            lane_pat[i] = (i % (1 << esz_q)) == 0;
    end

    AST_MASK_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((pmask & ~lane_pat) == '0));  // R8

    AST_FULL_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && inclusive_sel && wide_sel && unsigned_sel && (&bound_b))
        |=> (!flag_z && !flag_c && flag_n));  // R4

    AST_EQUAL_EXCL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !inclusive_sel && (bound_a == bound_b)) |=> flag_z);  // R6

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(pmask) && !out_valid));  // R10

    AST_N_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flag_n |-> !flag_z);  // R9

endmodule

// File: tb/loop_pred_gen_tb_top.sv
module loop_pred_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int VLEN_BITS  = 256;
    localparam int PW         = VLEN_BITS / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [63:0]   bound_a = '0;
    logic [63:0]   bound_b = '0;
    logic          wide_sel = 1'b0;
    logic          unsigned_sel = 1'b0;
    logic          inclusive_sel = 1'b0;
    logic [1:0]    elem_size = 2'd0;
    logic          out_valid;
    logic [PW-1:0] pmask;
    logic          flag_n, flag_z, flag_c, flag_v;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [PW-1:0] last_mask = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    loop_pred_gen #(.VLEN_BITS(VLEN_BITS)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .bound_a(bound_a), .bound_b(bound_b),
        .wide_sel(wide_sel), .unsigned_sel(unsigned_sel),
        .inclusive_sel(inclusive_sel), .elem_size(elem_size),
        .out_valid(out_valid), .pmask(pmask),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
    );

    task automatic chk_vec(string tag, logic [PW-1:0] got, logic [PW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s mask got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic chk_bit(string tag, string what, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %b expected %b", tag, what, got, exp);
        end
    endtask

    function automatic logic [63:0] ext(logic [63:0] v, bit w, bit u);
        if (w) return v;
        return u ? {32'b0, v[31:0]} : {{32{v[31]}}, v[31:0]};
    endfunction

    // Reference: step the first bound until the compare fails (R1..R8).
    function automatic logic [PW-1:0] ref_mask(logic [63:0] ra, logic [63:0] rb,
                                               bit w, bit u, bit inc, logic [1:0] es);
        logic [63:0] x = ext(ra, w, u);
        logic [63:0] b = ext(rb, w, u);
        logic [PW-1:0] m = '0;
        int nel = PW >> es;
        for (int e = 0; e < nel; e++) begin
            bit ok;
            if (u) ok = inc ? (x <= b) : (x < b);
            else   ok = inc ? ($signed(x) <= $signed(b)) : ($signed(x) < $signed(b));
            if (!ok) break;
            m[e << es] = 1'b1;
            x = ext(x + 64'd1, w, u);
        end
        return m;
    endfunction

    // Drive one request now (at a falling edge), check after the next edge.
    task automatic run_vec(string tag, logic [63:0] a, logic [63:0] b,
                           bit w, bit u, bit inc, logic [1:0] es);
        logic [PW-1:0] em;
        bound_a = a; bound_b = b; wide_sel = w; unsigned_sel = u;
        inclusive_sel = inc; elem_size = es; in_valid = 1'b1;
        em = ref_mask(a, b, w, u, inc, es);
        @(negedge clk);
        chk_vec(tag, pmask, em);
        chk_bit("R10", "out_valid", out_valid, 1'b1);
        chk_bit("R9", "flag_n", flag_n, em[0]);
        chk_bit("R9", "flag_z", flag_z, em == '0);
        chk_bit("R9", "flag_c", flag_c, !em[PW - (1 << es)]);
        chk_bit("R9", "flag_v", flag_v, 1'b0);
        last_mask = em;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk_bit("R10", "out_valid", out_valid, 1'b0);
        chk_vec("R10", pmask, '0);
        chk_bit("R10", "flag_n", flag_n, 1'b0);
        chk_bit("R10", "flag_z", flag_z, 1'b1);
        chk_bit("R10", "flag_c", flag_c, 1'b1);
        chk_bit("R10", "flag_v", flag_v, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 exclusive difference
        run_vec("R2", 64'd10, 64'd15, 1, 1, 0, 2'd0);
        run_vec("R2", 64'd100, 64'd103, 1, 0, 0, 2'd1);
        // R3 inclusive, equal bounds gives one element
        run_vec("R3", 64'd7, 64'd7, 1, 0, 1, 2'd0);
        run_vec("R3", 64'd4, 64'd6, 0, 1, 1, 2'd2);
        // R6 equal exclusive and reversed order
        run_vec("R6", 64'd9, 64'd9, 1, 1, 0, 2'd0);
        run_vec("R6", 64'd20, 64'd3, 1, 1, 1, 2'd0);
        run_vec("R6", 64'd5, 64'hFFFF_FFFF_FFFF_FFFE, 1, 0, 0, 2'd1);
        // R7 signed vs unsigned of -1 against 2
        run_vec("R7", '1, 64'd2, 1, 0, 0, 2'd0);
        run_vec("R7", '1, 64'd2, 1, 1, 0, 2'd0);
        run_vec("R7", '1, 64'd2, 1, 0, 1, 2'd0);
        run_vec("R7", '1, 64'd2, 1, 1, 1, 2'd0);
        // R1 narrowing ignores upper halves
        run_vec("R1", 64'hDEAD_BEEF_FFFF_FFFE, 64'h1234_5678_0000_0003, 0, 0, 0, 2'd0);
        run_vec("R1", 64'hDEAD_BEEF_FFFF_FFFE, 64'h1234_5678_0000_0003, 0, 1, 0, 2'd0);
        run_vec("R1", 64'h0000_0001_0000_0002, 64'h0000_0000_0000_0006, 0, 1, 0, 2'd0);
        // R5 clamp for each element size
        for (int s = 0; s < 4; s++) begin
            run_vec("R5", 64'd0, 64'd1000, 1, 1, 0, 2'(s));
            run_vec("R5", 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 1, 0, 1, 2'(s));
        end
        // R8 scaling, three elements at each size
        for (int s = 0; s < 4; s++)
            run_vec("R8", 64'd50, 64'd53, 1, 1, 0, 2'(s));
        // R4 each maximum integer, start at zero and just below
        for (int k = 0; k < 4; k++) begin
            bit w = k[1];
            bit u = k[0];
            logic [63:0] top = w ? (u ? '1 : 64'h7FFF_FFFF_FFFF_FFFF)
                                 : (u ? 64'hFFFF_FFFF : 64'h7FFF_FFFF);
            run_vec("R4", 64'd0, top, w, u, 1, 2'd0);
            run_vec("R4", top - 64'd1, top, w, u, 1, 2'd3);
            run_vec("R4", top, top, w, u, 1, 2'd1);
        end
        // R10 hold while idle
        in_valid = 1'b0;
        bound_a = 64'd0; bound_b = 64'd3;
        @(negedge clk);
        chk_vec("R10", pmask, last_mask);
        chk_bit("R10", "out_valid", out_valid, 1'b0);
        // R7 random sweep against the stepping reference
        for (int r = 0; r < 600; r++) begin
            logic [63:0] a = {$urandom, $urandom};
            logic [63:0] d = 64'($urandom_range(0, 40));
            logic [63:0] b;
            int kind = $urandom_range(0, 2);
            b = (kind == 0) ? {$urandom, $urandom} : (kind == 1) ? a + d : a - d;
            run_vec("R7", a, b, 1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom));
        end
        in_valid = 1'b0;
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule